// File: doc/BRIEF.md
# Scanline Interrupt Divider

This block produces the periodic maskable interrupt request for an 8-bit CPU by counting horizontal sync pulses from the video timing generator. A small line counter advances once per horizontal sync pulse, on the clock after the pulse ends. When it has counted a full period of lines (52 by default), it wraps to zero and raises a level interrupt request. The request stays raised until the CPU acknowledges it. Six such periods fill a standard frame.

Two paths let software and the frame timing move the interrupt phase. A vertical sync pulse arms a re-alignment. On the second line end after the pulse, the counter is cleared, so the interrupts lock to the frame. Software can also clear the counter and any pending request with a single I/O write. The next interrupt then falls a full period of lines after that write. Writing N lines after an interrupt therefore delays every later interrupt in the frame by N lines. An acknowledge drops the request and clears the top bit of the counter, so a late acknowledge cannot let a second request follow too soon.

The I/O write port is a valid/ready stream. `io_ready` is held high at all times, so there is no back-pressure. A write is consumed in every clock cycle in which `io_valid` is high. All other pins are plain levels sampled on the rising clock edge.

Top module: `scanline_irq_gen`

## Requirements
- R1: A line is counted only when `hsync` is sampled low on a clock edge after being sampled high on the previous edge. A pulse held high for many cycles counts once.
- R2: When the counted line would be the 52nd since the counter was last zero, the counter wraps to 0 and `irq` is high from the same clock edge onward.
- R3: Once raised, `irq` stays high until an acknowledge or a software clear.
- R4: A cycle with `int_ack` high drops `irq` on that edge. It also clears counter bit 5, so a count of 40 becomes 8 and the next request comes 44 lines later.
- R5: If an acknowledge falls on the same edge as the 52nd line while the count is 51, bit 5 is cleared first, the line is counted from 19 to 20, and no request is raised. The next request follows 32 lines later.
- R6: A write with `io_addr_hi` = 0x7F, `io_data[7:6]` = 2'b10 and `io_data[4]` = 1 (for example 0x95 or 0x9D) clears the counter and the pending request. The next request comes exactly 52 lines later.
- R7: A write with any other address, with `io_data[4]` = 0, or with `io_data[7:6]` other than 2'b10, leaves the counter and the request unchanged.
- R8: A rising edge on `vsync` arms re-alignment. The first line end afterwards is counted normally. On the second, the counter is cleared, and `irq` is raised if the counter held 32 or more.
- R9: If the counter held less than 32 at that re-alignment point, it is cleared and no request is raised.
- R10: While `rst_n` is low, the counter, the armed re-alignment and `irq` are cleared. After reset, the first request follows 52 lines.
- R11: `io_ready` is always high, so every write is taken in its cycle.
- R12: A software clear wins over a line end, an acknowledge or a re-alignment in the same cycle: `irq` ends low and counting restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync | input | 1 | Horizontal sync pulse, active high |
| vsync | input | 1 | Vertical sync pulse, active high |
| int_ack | input | 1 | CPU interrupt acknowledge, active high |
| io_valid | input | 1 | I/O write strobe (stream valid) |
| io_ready | output | 1 | Always 1, write accepted |
| io_addr_hi | input | 8 | Upper byte of the I/O address |
| io_data | input | 8 | I/O write data |
| irq | output | 1 | Interrupt request, level, active high |

## Verification
The bench builds the block with its default parameters: a 6-bit counter, a 52-line period, a two-line re-alignment delay and I/O page 0x7F. With these values, bit 5 of the counter is the bit that an acknowledge clears. The 32-line threshold that decides whether a re-alignment raises a request is also reachable. Both sides of that threshold can be driven within a few hundred clocks, as can the acknowledge that lands on the wrap line. A period of 52 lines keeps a full divider cycle, including the requests that follow a shifted phase, short enough to walk many times.

// File: rtl/scl_pkg.sv
package scl_pkg;

  localparam int unsigned SCL_CNT_W       = 6;
  localparam int unsigned SCL_PERIOD      = 52;
  localparam int unsigned SCL_ALIGN_LINES = 2;
  localparam logic [7:0]  SCL_IO_PAGE     = 8'h7F;

  typedef enum logic [1:0] {
    LEV_NONE  = 2'd0,
    LEV_COUNT = 2'd1,
    LEV_ALIGN = 2'd2
  } line_evt_e;

endpackage

// File: rtl/scl_edge_det.sv
module scl_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = sig & ~prev_q;
    end else begin : g_fall
      assign pulse = prev_q & ~sig;
    end
  endgenerate
endmodule

// File: rtl/scl_io_match.sv
module scl_io_match #(
  parameter logic [7:0] PAGE = 8'h7F
) (
  input  logic       valid,
  input  logic [7:0] addr_hi,
  input  logic [7:0] data,
  output logic       hit
);
  logic page_ok, func_ok, clr_bit;

  always_comb begin
    page_ok = (addr_hi == PAGE);
    func_ok = (data[7:6] == 2'b10);
    clr_bit = data[4];
    hit     = valid & page_ok & func_ok & clr_bit;
  end
endmodule

// File: rtl/scl_frame_align.sv
module scl_frame_align
  import scl_pkg::*;
#(
  parameter int unsigned ALIGN_LINES = SCL_ALIGN_LINES
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vs_rise,
  input  logic      hs_fall,
  output line_evt_e evt
);
  localparam int unsigned LW = $clog2(ALIGN_LINES + 1);
  localparam logic [LW-1:0] ARM_VAL = LW'(ALIGN_LINES);
  localparam logic [LW-1:0] ONE     = LW'(1);

  logic [LW-1:0] left_q;
  logic          last_line;

  assign last_line = (left_q == ONE) && !vs_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (vs_rise) begin
      left_q <= ARM_VAL;
    end else if (hs_fall && left_q != '0) begin
      left_q <= left_q - ONE;
    end
  end

  always_comb begin
    evt = LEV_NONE;
    if (hs_fall) evt = last_line ? LEV_ALIGN : LEV_COUNT;
  end
endmodule

// File: rtl/scl_line_divider.sv
module scl_line_divider
  import scl_pkg::*;
#(
  parameter int unsigned CNT_W  = SCL_CNT_W,
  parameter int unsigned PERIOD = SCL_PERIOD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  line_evt_e        evt,
  input  logic             ack,
  input  logic             sw_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             irq_q, irq_n;

  always_comb begin
    cnt_n = cnt_q;
    irq_n = irq_q;
    if (ack) begin
      cnt_n[CNT_W-1] = 1'b0;
      irq_n          = 1'b0;
    end
    unique case (evt)
      LEV_COUNT: begin
        if (cnt_n == LAST) begin
          cnt_n = '0;
          irq_n = 1'b1;
        end else begin
          cnt_n = cnt_n + STEP;
        end
      end
      LEV_ALIGN: begin
        if (cnt_n >= HALF) irq_n = 1'b1;
        cnt_n = '0;
      end
      default: ;
    endcase
    if (sw_clr) begin
      cnt_n = '0;
      irq_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      irq_q <= irq_n;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
  import scl_pkg::*;
#(
  parameter int unsigned CNT_W         = SCL_CNT_W,
  parameter int unsigned LINES_PER_IRQ = SCL_PERIOD,
  parameter int unsigned ALIGN_LINES   = SCL_ALIGN_LINES,
  parameter logic [7:0]  IO_PAGE       = SCL_IO_PAGE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       int_ack,
  input  logic       io_valid,
  output logic       io_ready,
  input  logic [7:0] io_addr_hi,
  input  logic [7:0] io_data,
  output logic       irq
);
  logic             hs_fall, vs_rise, sw_clr;
  line_evt_e        evt;
  logic [CNT_W-1:0] line_cnt;

  assign io_ready = 1'b1;

  scl_edge_det #(.RISING(1'b0)) u_hs_edge (
    .clk(clk), .rst_n(rst_n), .sig(hsync), .pulse(hs_fall)
  );

  scl_edge_det #(.RISING(1'b1)) u_vs_edge (
    .clk(clk), .rst_n(rst_n), .sig(vsync), .pulse(vs_rise)
  );

  scl_io_match #(.PAGE(IO_PAGE)) u_io (
    .valid(io_valid), .addr_hi(io_addr_hi), .data(io_data), .hit(sw_clr)
  );

  scl_frame_align #(.ALIGN_LINES(ALIGN_LINES)) u_align (
    .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .hs_fall(hs_fall), .evt(evt)
  );

  scl_line_divider #(.CNT_W(CNT_W), .PERIOD(LINES_PER_IRQ)) u_div (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ack(int_ack), .sw_clr(sw_clr),
    .cnt(line_cnt), .irq(irq)
  );
endmodule

// File: rtl/scanline_irq_gen_chk.sv
module scanline_irq_gen_chk #(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned PERIOD  = 52,
  parameter logic [7:0]  IO_PAGE = 8'h7F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic             int_ack,
  input logic             io_valid,
  input logic [7:0]       io_addr_hi,
  input logic [7:0]       io_data,
  input logic             irq,
  input logic [CNT_W-1:0] line_cnt
);
  logic hs_seen_q, hs_end, wr_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) hs_seen_q <= 1'b0;
    else        hs_seen_q <= hsync;
  end

  assign hs_end = hs_seen_q && !hsync;
  assign wr_clr = io_valid && (io_addr_hi == IO_PAGE) && io_data[7] && !io_data[6] && io_data[4];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt < CNT_W'(PERIOD)); // R2

  AST_RISE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hs_end)); // R1

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !int_ack && !wr_clr |=> irq); // R3

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && !hs_end |=> !irq); // R4

  AST_ACK_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && !hs_end && !wr_clr |=> !line_cnt[CNT_W-1]); // R4

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !irq && line_cnt == '0); // R6
endmodule

bind scanline_irq_gen scanline_irq_gen_chk #(
  .CNT_W(CNT_W), .PERIOD(LINES_PER_IRQ), .IO_PAGE(IO_PAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .int_ack(int_ack),
  .io_valid(io_valid), .io_addr_hi(io_addr_hi), .io_data(io_data),
  .irq(irq), .line_cnt(line_cnt)
);

// File: tb/scanline_irq_gen_bench.sv
`timescale 1ns/1ps
module scanline_irq_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0, vsync = 1'b0, int_ack = 1'b0, io_valid = 1'b0;
  logic [7:0] io_addr_hi = 8'h00, io_data = 8'h00;
  logic       io_ready, irq;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  scanline_irq_gen u_scanline_irq_gen (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .int_ack(int_ack),
    .io_valid(io_valid), .io_ready(io_ready), .io_addr_hi(io_addr_hi),
    .io_data(io_data), .irq(irq)
  );

  // op: 0 line pulses, 1 acknowledge, 2 I/O write {addr,data}, 3 vsync pulse
  localparam int NV = 39;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 16'd51,    1'b0, 4'd1},  // R1 count short of period
    {2'd0, 16'd1,     1'b1, 4'd2},  // R2 52nd line raises
    {2'd0, 16'd5,     1'b1, 4'd3},  // R3 held
    {2'd1, 16'd0,     1'b0, 4'd4},  // R4 ack drops
    {2'd0, 16'd46,    1'b0, 4'd2},
    {2'd0, 16'd1,     1'b1, 4'd2},
    {2'd1, 16'd0,     1'b0, 4'd4},
    {2'd0, 16'd40,    1'b0, 4'd6},
    {2'd2, 16'h7F95,  1'b0, 4'd6},  // R6 clear
    {2'd0, 16'd51,    1'b0, 4'd6},
    {2'd0, 16'd1,     1'b1, 4'd6},
    {2'd1, 16'd0,     1'b0, 4'd4},
    {2'd0, 16'd10,    1'b0, 4'd7},
    {2'd2, 16'h7F8D,  1'b0, 4'd7},  // R7 bit4 low
    {2'd2, 16'h7E95,  1'b0, 4'd7},  // R7 wrong page
    {2'd2, 16'h7FD5,  1'b0, 4'd7},  // R7 top bits 11
    {2'd0, 16'd41,    1'b0, 4'd7},
    {2'd0, 16'd1,     1'b1, 4'd7},
    {2'd1, 16'd0,     1'b0, 4'd4},
    {2'd0, 16'd40,    1'b0, 4'd4},
    {2'd1, 16'd0,     1'b0, 4'd4},  // R4 40 -> 8
    {2'd0, 16'd43,    1'b0, 4'd4},
    {2'd0, 16'd1,     1'b1, 4'd4},
    {2'd1, 16'd0,     1'b0, 4'd4},
    {2'd0, 16'd35,    1'b0, 4'd8},
    {2'd3, 16'd0,     1'b0, 4'd8},  // R8 arm
    {2'd0, 16'd1,     1'b0, 4'd8},
    {2'd0, 16'd1,     1'b1, 4'd8},  // R8 realign at 36
    {2'd1, 16'd0,     1'b0, 4'd4},
    {2'd0, 16'd51,    1'b0, 4'd8},
    {2'd0, 16'd1,     1'b1, 4'd8},
    {2'd1, 16'd0,     1'b0, 4'd4},
    {2'd0, 16'd10,    1'b0, 4'd9},
    {2'd3, 16'd0,     1'b0, 4'd9},  // R9 arm
    {2'd0, 16'd1,     1'b0, 4'd9},
    {2'd0, 16'd1,     1'b0, 4'd9},  // R9 realign at 11, silent
    {2'd0, 16'd51,    1'b0, 4'd9},
    {2'd0, 16'd1,     1'b1, 4'd9},
    {2'd1, 16'd0,     1'b0, 4'd4}
  };

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) hsync = 1'b1;
      @(negedge clk) hsync = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk) int_ack = 1'b1;
    @(negedge clk) int_ack = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk) begin io_valid = 1'b1; io_addr_hi = a; io_data = d; end
    @(negedge clk) io_valid = 1'b0;
  endtask

  task automatic vs();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(irq, 1'b0, "R10 reset irq");
    check(io_ready, 1'b1, "R11 ready in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [1:0]  op;
      logic [15:0] arg;
      logic        exp;
      logic [3:0]  rq;
      {op, arg, exp, rq} = VEC[k];
      case (op)
        2'd0: lines(int'(arg));
        2'd1: ack();
        2'd2: wr(arg[15:8], arg[7:0]);
        default: vs();
      endcase
      check(irq, exp, $sformatf("R%0d vector %0d", rq, k));
    end

    // R1: long high pulse counts once
    lines(50);
    @(negedge clk) hsync = 1'b1;
    repeat (6) @(negedge clk);
    hsync = 1'b0;
    @(negedge clk);
    check(irq, 1'b0, "R1 long pulse line 51");
    lines(1);
    check(irq, 1'b1, "R1 long pulse line 52");
    check(io_ready, 1'b1, "R11 ready running");
    ack();

    // R5: ack on the wrap line
    lines(52);
    check(irq, 1'b1, "R5 setup");
    lines(51);
    @(negedge clk) hsync = 1'b1;
    @(negedge clk) begin hsync = 1'b0; int_ack = 1'b1; end
    @(negedge clk) int_ack = 1'b0;
    check(irq, 1'b0, "R5 ack on wrap line");
    lines(31);
    check(irq, 1'b0, "R5 count 20 to 51");
    lines(1);
    check(irq, 1'b1, "R5 request 32 lines on");
    ack();

    // R12: clear with a coincident line end and pending request
    lines(52);
    lines(51);
    @(negedge clk) hsync = 1'b1;
    @(negedge clk) begin hsync = 1'b0; io_valid = 1'b1; io_addr_hi = 8'h7F; io_data = 8'h9D; end
    @(negedge clk) io_valid = 1'b0;
    check(irq, 1'b0, "R12 clear wins");
    lines(51);
    check(irq, 1'b0, "R12 restarted from 0");
    lines(1);
    check(irq, 1'b1, "R12 next after 52");
    ack();

    // R10: reset mid-count
    lines(30);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    lines(51);
    check(irq, 1'b0, "R10 count cleared");
    lines(1);
    check(irq, 1'b1, "R10 first after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule